// File: doc/BRIEF.md
# Message Bus Register Target

This block is the responding end of a narrow register access link between a link-layer controller and a physical-layer device. Requests arrive as a stream of bytes, one per clock, on an 8-bit inbound bus; each request packs a 4-bit command and a 12-bit address, and write requests carry one data byte as well. The block hosts a small set of 8-bit registers in that address space. It sends its replies one byte per clock on an 8-bit outbound bus.

Writes come in two kinds. A staged write is held in a small buffer and has no effect yet. A committing write then applies itself and every staged write in one clock edge, so that several control fields change together. The block then returns an acknowledge byte. A read is answered with a completion byte followed by the data byte. Each register bit is either a level bit, which holds its value, or a pulse bit, which stays high for one cycle after a write of one and then clears itself. Local logic uses the register contents through a flat output vector.

Top module: `msgbus_target`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, every register reads 0x00 and the outbound bus carries 0x00.
- R2: The first byte of a request holds the command in bits [7:4] and address bits [11:8] in bits [3:0]. The second byte holds address bits [7:0], and write requests add a third byte with the data. The command codes are: 0 idle, 1 staged write, 2 committing write, 3 read, 4 read completion, 5 write acknowledge. A first byte whose command is not 1, 2 or 3 is ignored and produces no reply.
- R3: A staged write changes no register and produces no reply.
- R4: On the edge that takes in a committing write's data byte, every buffered staged write and the committing write update their registers together, and the buffer is emptied.
- R5: When more than one pending write targets the same address, the last one wins. Staged writes apply in arrival order and the committing write applies after them.
- R6: The buffer holds up to BUF_DEPTH (default 4) staged writes. A staged write that arrives while the buffer is full is discarded.
- R7: In the cycle after the committing data byte, the outbound bus carries 0x50 (acknowledge), and the registers show the new values in that same cycle. The bus returns to 0x00 in the following cycle.
- R8: A read request gets 0x40 (completion) on the outbound bus in the cycle after its address byte. The next cycle carries the register data, and the bus then returns to 0x00.
- R9: Level bits keep their value until a later committing write changes them or reset occurs.
- R10: A pulse bit written with 1 reads 1 for exactly the cycle in which the commit becomes visible, then 0. The default pulse masks are 0x01, 0x80, 0x00 and 0xF0 for registers 0 to 3.
- R11: Address bits [11:10] select the region: 00 receive, 01 transmit, 10 common, 11 vendor. By default register 0 sits at 0x000, register 1 at 0x400, and registers 2 and 3 at 0x800 and 0x801. The vendor region holds no register. A write to an address that holds no register is discarded but still acknowledged, and a read of such an address returns 0x00.
- R12: Idle bytes (command 0) between staged writes, or between staged writes and the committing write, leave the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| rx_byte | input | 8 | Inbound request byte stream |
| tx_byte | output | 8 | Outbound reply byte stream |
| reg_out | output | NREG*8 | Register contents, register 0 in the low byte |

## Verification
The properties assume a requester that follows the link rules. Requests arrive fully framed with no gaps inside a request. After a committing write, nothing new is sent until the acknowledge has been seen. A read is never started while a reply is still leaving the block. Under these rules commits are at least three cycles apart, which is what lets the pulse-clearing and acknowledge properties be checked one cycle after the event.

The stimulus sends only whole requests from tasks that wait out each reply before the next request begins. Illegal command codes are placed only where a first byte is expected. The one deliberate overload is a fifth staged write against a full buffer.

// File: rtl/msgbus_pkg.sv
`timescale 1ns/1ps
package msgbus_pkg;
  localparam int CMD_W  = 4;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int BYTE_W = CMD_W + ADDR_W - DATA_W;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP    = 4'd0,
    CMD_WR_STG = 4'd1,
    CMD_WR_COM = 4'd2,
    CMD_RD     = 4'd3,
    CMD_RD_CPL = 4'd4,
    CMD_WR_ACK = 4'd5
  } cmd_e;

  typedef enum logic [1:0] {
    PS_CMD,
    PS_ADDR,
    PS_DATA
  } parse_st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/msgbus_rx_parser.sv
`timescale 1ns/1ps
module msgbus_rx_parser
  import msgbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              stage_o,
  output logic              commit_o,
  output wr_req_t           wr_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  localparam int HI_W = ADDR_W - DATA_W;

  parse_st_e         state_q, state_d;
  cmd_e              cmd_q, cmd_d;
  logic [HI_W-1:0]   ahi_q, ahi_d;
  logic [DATA_W-1:0] alo_q, alo_d;
  logic              upd_en;

  always_comb begin
    state_d   = state_q;
    cmd_d     = cmd_q;
    ahi_d     = ahi_q;
    alo_d     = alo_q;
    stage_o   = 1'b0;
    commit_o  = 1'b0;
    rd_req_o  = 1'b0;
    rd_addr_o = '0;
    wr_o      = '0;
    case (state_q)
      PS_CMD: begin
        case (rx_byte[DATA_W-1 -: CMD_W])
          CMD_WR_STG, CMD_WR_COM, CMD_RD: begin
            cmd_d   = cmd_e'(rx_byte[DATA_W-1 -: CMD_W]);
            ahi_d   = rx_byte[HI_W-1:0];
            state_d = PS_ADDR;
          end
          default: state_d = PS_CMD;
        endcase
      end
      PS_ADDR: begin
        alo_d = rx_byte;
        if (cmd_q == CMD_RD) begin
          rd_req_o  = 1'b1;
          rd_addr_o = {ahi_q, rx_byte};
          state_d   = PS_CMD;
        end else begin
          state_d = PS_DATA;
        end
      end
      PS_DATA: begin
        wr_o.addr = {ahi_q, alo_q};
        wr_o.data = rx_byte;
        stage_o   = (cmd_q == CMD_WR_STG);
        commit_o  = (cmd_q == CMD_WR_COM);
        state_d   = PS_CMD;
      end
      default: state_d = PS_CMD;
    endcase
  end

  assign upd_en = (state_q != PS_CMD) || (state_d != PS_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_CMD;
      cmd_q   <= CMD_NOP;
      ahi_q   <= '0;
      alo_q   <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      ahi_q   <= ahi_d;
      alo_q   <= alo_d;
    end
  end
endmodule

// File: rtl/msgbus_wr_buffer.sv
`timescale 1ns/1ps
module msgbus_wr_buffer
  import msgbus_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push_i,
  input  wr_req_t               push_req_i,
  input  logic                  clear_i,
  output logic [CNT_W-1:0]      cnt_o,
  output wr_req_t [DEPTH-1:0]   ent_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full;
  logic             accept;
  logic             cnt_en;

  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign accept = push_i && !full;
  assign cnt_en = accept || clear_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)     cnt_d = '0;
    else if (accept) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    wr_req_t slot_q;
    logic    slot_en;

    assign slot_en = accept && (cnt_q == CNT_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= push_req_i;
    end

    assign ent_o[i] = slot_q;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/msgbus_regfile.sv
`timescale 1ns/1ps
module msgbus_regfile
  import msgbus_pkg::*;
#(
  parameter int NREG = 4,
  parameter int DEPTH = 4,
  parameter logic [NREG*ADDR_W-1:0] REG_ADDRS = {12'h801, 12'h800, 12'h400, 12'h000},
  parameter logic [NREG*DATA_W-1:0] PULSE_MASKS = {8'hF0, 8'h00, 8'h80, 8'h01},
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  wr_req_t [DEPTH-1:0]      ent_i,
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic                     commit_i,
  input  wr_req_t                  com_req_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic [NREG*DATA_W-1:0]   regs_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam logic [ADDR_W-1:0] RA = REG_ADDRS[r*ADDR_W +: ADDR_W];
    localparam logic [DATA_W-1:0] PM = PULSE_MASKS[r*DATA_W +: DATA_W];

    logic [DATA_W-1:0] q, d, merged;
    logic              en;

    always_comb begin
      merged = q & ~PM;
      for (int e = 0; e < DEPTH; e++) begin
        if ((e < int'(cnt_i)) && (ent_i[e].addr == RA)) merged = ent_i[e].data;
      end
      if (com_req_i.addr == RA) merged = com_req_i.data;
    end

    always_comb begin
      d = commit_i ? merged : (q & ~PM);
    end

    assign en = commit_i || ((q & PM) != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign regs_o[r*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int r = 0; r < NREG; r++) begin
      if (rd_addr_i == REG_ADDRS[r*ADDR_W +: ADDR_W]) rd_data_o = regs_o[r*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/msgbus_tx.sv
`timescale 1ns/1ps
module msgbus_tx
  import msgbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] tx_o
);
  localparam logic [CMD_W-1:0] ZERO_NIB = '0;

  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_v_q, hold_v_d;
  logic              hold_en;

  always_comb begin
    tx_d     = '0;
    hold_d   = hold_q;
    hold_v_d = 1'b0;
    if (rd_req_i) begin
      tx_d     = {CMD_RD_CPL, ZERO_NIB};
      hold_d   = rd_data_i;
      hold_v_d = 1'b1;
    end else if (hold_v_q) begin
      tx_d = hold_q;
    end else if (ack_i) begin
      tx_d = {CMD_WR_ACK, ZERO_NIB};
    end
  end

  assign hold_en = rd_req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q     <= '0;
      hold_v_q <= 1'b0;
    end else begin
      tx_q     <= tx_d;
      hold_v_q <= hold_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign tx_o = tx_q;
endmodule

// File: rtl/msgbus_target.sv
`timescale 1ns/1ps
module msgbus_target
  import msgbus_pkg::*;
#(
  parameter int NREG = 4,
  parameter int BUF_DEPTH = 4,
  parameter logic [NREG*ADDR_W-1:0] REG_ADDRS = {12'h801, 12'h800, 12'h400, 12'h000},
  parameter logic [NREG*DATA_W-1:0] PULSE_MASKS = {8'hF0, 8'h00, 8'h80, 8'h01}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             rx_byte,
  output logic [7:0]             tx_byte,
  output logic [NREG*8-1:0]      reg_out
);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  logic                      wr_stage;
  logic                      wr_commit;
  wr_req_t                   wr_req;
  logic                      rd_req;
  logic [ADDR_W-1:0]         rd_addr;
  logic [DATA_W-1:0]         rd_data;
  logic [CNT_W-1:0]          buf_cnt;
  wr_req_t [BUF_DEPTH-1:0]   buf_ent;

  msgbus_rx_parser u_parser (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_byte   (rx_byte),
    .stage_o   (wr_stage),
    .commit_o  (wr_commit),
    .wr_o      (wr_req),
    .rd_req_o  (rd_req),
    .rd_addr_o (rd_addr)
  );

  msgbus_wr_buffer #(.DEPTH(BUF_DEPTH)) u_buffer (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (wr_stage),
    .push_req_i (wr_req),
    .clear_i    (wr_commit),
    .cnt_o      (buf_cnt),
    .ent_o      (buf_ent)
  );

  msgbus_regfile #(
    .NREG        (NREG),
    .DEPTH       (BUF_DEPTH),
    .REG_ADDRS   (REG_ADDRS),
    .PULSE_MASKS (PULSE_MASKS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ent_i     (buf_ent),
    .cnt_i     (buf_cnt),
    .commit_i  (wr_commit),
    .com_req_i (wr_req),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .regs_o    (reg_out)
  );

  msgbus_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req_i  (rd_req),
    .rd_data_i (rd_data),
    .ack_i     (wr_commit),
    .tx_o      (tx_byte)
  );
endmodule

// File: rtl/msgbus_target_chk.sv
`timescale 1ns/1ps
module msgbus_target_chk #(
  parameter int NREG = 4,
  parameter int DEPTH = 4,
  parameter logic [NREG*8-1:0] PULSE_MASKS = {8'hF0, 8'h00, 8'h80, 8'h01}
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [7:0]                   tx_byte,
  input logic [NREG*8-1:0]            regs,
  input logic                         commit,
  input logic                         stage,
  input logic                         rd_req,
  input logic [$clog2(DEPTH+1)-1:0]   buf_cnt
);
  localparam logic [NREG*8-1:0] LEVEL_BITS = ~PULSE_MASKS;

  // R3
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage |=> $stable(regs & LEVEL_BITS));

  // R4
  buf_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (buf_cnt == '0));

  // R6
  buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_cnt <= ($clog2(DEPTH+1))'(DEPTH));

  // R7
  ack_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (tx_byte == 8'h50));

  // R8
  cpl_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (tx_byte == 8'h40));

  // R9
  level_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(regs & LEVEL_BITS));

  // R10
  pulse_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((regs & PULSE_MASKS) != '0) |=> ((regs & PULSE_MASKS) == '0));
endmodule

bind msgbus_target msgbus_target_chk #(
  .NREG        (NREG),
  .DEPTH       (BUF_DEPTH),
  .PULSE_MASKS (PULSE_MASKS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tx_byte (tx_byte),
  .regs    (reg_out),
  .commit  (wr_commit),
  .stage   (wr_stage),
  .rd_req  (rd_req),
  .buf_cnt (buf_cnt)
);

// File: tb/test_msgbus_target.sv
`timescale 1ns/1ps
module test_msgbus_target;
  localparam time CLK_P = 4ns;
  localparam int  NR = 4;
  localparam int  BD = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [7:0]      rx_byte;
  logic [7:0]      tx_byte;
  logic [NR*8-1:0] reg_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [11:0] raddr [NR] = '{12'h000, 12'h400, 12'h800, 12'h801};
  logic [7:0]  pmask [NR] = '{8'h01, 8'h80, 8'h00, 8'hF0};
  logic [7:0]  exp_lvl [NR];
  logic [11:0] stg_a [BD];
  logic [7:0]  stg_d [BD];
  int          scnt;

  always #(CLK_P/2) clk = ~clk;

  msgbus_target i_msgbus_target (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_byte (rx_byte),
    .tx_byte (tx_byte),
    .reg_out (reg_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [11:0] a);
    for (int r = 0; r < NR; r++) if (raddr[r] == a) return r;
    return -1;
  endfunction

  function automatic logic [31:0] pack_lvl();
    logic [31:0] v;
    for (int r = 0; r < NR; r++) v[r*8 +: 8] = exp_lvl[r];
    return v;
  endfunction

  task automatic step(input logic [7:0] b);
    @(negedge clk);
    rx_byte = b;
    @(posedge clk);
    #1;
  endtask

  task automatic stage_wr(input logic [11:0] a, input logic [7:0] d);
    step({4'h1, a[11:8]});
    step(a[7:0]);
    step(d);
    chk(tx_byte == 8'h00, "R3", tx_byte, 0);
    chk(reg_out == pack_lvl(), "R3", reg_out, pack_lvl());
    if (scnt < BD) begin
      stg_a[scnt] = a;
      stg_d[scnt] = d;
      scnt++;
    end
  endtask

  task automatic commit_wr(input logic [11:0] a, input logic [7:0] d, input string tag);
    logic [31:0] raw;
    step({4'h2, a[11:8]});
    step(a[7:0]);
    step(d);
    for (int r = 0; r < NR; r++) begin
      logic [7:0] v;
      v = exp_lvl[r];
      for (int e = 0; e < scnt; e++) if (stg_a[e] == raddr[r]) v = stg_d[e];
      if (a == raddr[r]) v = d;
      raw[r*8 +: 8] = v;
      exp_lvl[r] = v & ~pmask[r];
    end
    scnt = 0;
    chk(tx_byte == 8'h50, "R7", tx_byte, 32'h50);
    chk(reg_out == raw, tag, reg_out, raw);
    step(8'h00);
    chk(reg_out == pack_lvl(), "R10", reg_out, pack_lvl());
    chk(tx_byte == 8'h00, "R7", tx_byte, 0);
  endtask

  task automatic read_chk(input logic [11:0] a, input string tag);
    int k;
    logic [7:0] e;
    k = idx_of(a);
    e = (k >= 0) ? exp_lvl[k] : 8'h00;
    step({4'h3, a[11:8]});
    step(a[7:0]);
    chk(tx_byte == 8'h40, "R8", tx_byte, 32'h40);
    step(8'h00);
    chk(tx_byte == e, tag, tx_byte, e);
    step(8'h00);
    chk(tx_byte == 8'h00, "R8", tx_byte, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [11:0] unimpl [8] = '{12'h001, 12'h3FF, 12'h401, 12'h7FF, 12'h802, 12'hC00, 12'hC01, 12'hFFF};
    scnt = 0;
    for (int r = 0; r < NR; r++) exp_lvl[r] = 8'h00;
    rst_n = 1'b0;
    rx_byte = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk(reg_out == '0, "R1", reg_out, 0);
    chk(tx_byte == 8'h00, "R1", tx_byte, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(8'h00);
    chk(reg_out == '0, "R1", reg_out, 0);
    chk(tx_byte == 8'h00, "R1", tx_byte, 0);

    // R9 R10: every data value into every register, read back
    for (int r = 0; r < NR; r++) begin
      for (int d = 0; d < 256; d++) begin
        commit_wr(raddr[r], 8'(d), "R10");
        read_chk(raddr[r], "R9");
      end
    end

    // R11: writes to empty addresses are acknowledged but discarded
    commit_wr(12'h000, 8'h5A, "R9");
    commit_wr(12'h400, 8'h3C, "R9");
    commit_wr(12'h800, 8'hC3, "R9");
    commit_wr(12'h801, 8'h0F, "R9");
    for (int i = 0; i < 8; i++) begin
      commit_wr(unimpl[i], 8'hFF, "R11");
      chk(reg_out == pack_lvl(), "R11", reg_out, pack_lvl());
    end
    // R11: read sweep across the whole address space
    for (int a = 0; a < 4096; a++) read_chk(12'(a), "R11");

    // R3 R4 R12: staged writes with idle bytes between, applied together
    stage_wr(12'h000, 8'hA4);
    step(8'h00);
    step(8'h00);
    chk(reg_out == pack_lvl(), "R12", reg_out, pack_lvl());
    stage_wr(12'h400, 8'hFF);
    step(8'h00);
    chk(reg_out == pack_lvl(), "R12", reg_out, pack_lvl());
    stage_wr(12'h800, 8'h77);
    step(8'h00);
    commit_wr(12'h801, 8'hF6, "R4");
    read_chk(12'h400, "R4");

    // R5: later writes to one address win
    stage_wr(12'h400, 8'h11);
    stage_wr(12'h400, 8'h22);
    commit_wr(12'h800, 8'h33, "R5");
    read_chk(12'h400, "R5");
    stage_wr(12'h800, 8'h44);
    commit_wr(12'h800, 8'h55, "R5");
    read_chk(12'h800, "R5");

    // R6: fifth staged write against a full buffer is dropped
    stage_wr(12'h000, 8'h10);
    stage_wr(12'h400, 8'h20);
    stage_wr(12'h800, 8'h30);
    stage_wr(12'h801, 8'h40);
    stage_wr(12'h000, 8'h50);
    commit_wr(12'hFFF, 8'h00, "R6");
    read_chk(12'h000, "R6");
    // R4: buffer emptied, a lone commit carries no old entries
    commit_wr(12'h801, 8'h01, "R4");
    read_chk(12'h000, "R4");

    // R2: first bytes with other command codes are ignored
    step(8'h4A);
    chk(tx_byte == 8'h00, "R2", tx_byte, 0);
    step(8'h5B);
    chk(tx_byte == 8'h00, "R2", tx_byte, 0);
    step(8'hF3);
    chk(tx_byte == 8'h00, "R2", tx_byte, 0);
    step(8'h0C);
    chk(tx_byte == 8'h00, "R2", tx_byte, 0);
    chk(reg_out == pack_lvl(), "R2", reg_out, pack_lvl());
    read_chk(12'h800, "R2");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule